// File: doc/BRIEF.md
# Next-PC Sequencer with Branch Delay Slot

This block holds the program counter of a core whose branches and jumps have an architectural delay slot. The instruction after a branch always executes. When the branch is taken, control moves to the target only after that following instruction retires. Every time an instruction retires, the block takes in that instruction's size, whether it is a branch, whether the branch is taken, whether it is a branch-likely, and its target. From these it forms the address of the next instruction.

Alongside the PC the block gives two flags. The first marks an instruction that really executes as the slot of a preceding branch. The second marks a slot that must be squashed because a branch-likely was not taken. Squashing removes the slot's effects and its exceptions. An exception redirect input overrides all sequencing and drops any branch target that is still waiting. A branch placed inside a delay slot has no defined result. The block flags this case and ignores that branch's redirect.

Top module: `npc_unit`

## Requirements
- R1: After reset, `pc` equals the RESET_PC parameter, and `in_slot` and `nullify` are 0.
- R2: When a non-branch instruction retires outside any slot, `pc` advances by 4 if `half_size` is 0, or by 2 if `half_size` is 1.
- R3: In a cycle with neither `retire` nor `exc_valid`, `pc`, `in_slot` and `nullify` keep their values.
- R4: When a taken branch retires, `pc` moves to the sequential slot address. When the slot retires next, `pc` becomes the branch target.
- R5: `in_slot` is 1 for exactly the one instruction after a retired branch, whether or not the branch was taken, and 0 otherwise.
- R6: The instruction reached at a branch target has `in_slot` 0, even when its address directly follows the slot.
- R7: When a branch-likely retires not taken, `nullify` is 1 for exactly the next retired instruction, and `pc` advances sequentially.
- R8: When a branch-likely retires taken, `nullify` stays 0 and the redirect follows R4.
- R9: When a branch retires while `in_slot` is 1, `unpredictable` is 1 in that cycle and the branch is ignored. The PC still goes to the earlier branch's target, and the next instruction is not in a slot.
- R10: `exc_valid` loads `exc_vector` into `pc` on the next edge, and clears `in_slot`, `nullify` and any waiting target. This holds even in the middle of a slot.
- R11: When a plain branch retires not taken, the PC stays sequential and `nullify` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire | input | 1 | Current instruction retires this cycle |
| half_size | input | 1 | Current instruction is 16-bit (ISA mode bit) |
| is_branch | input | 1 | Current instruction is a branch or jump |
| taken | input | 1 | Branch is taken |
| likely | input | 1 | Branch is of the likely kind |
| target | input | AW | Branch target address |
| exc_valid | input | 1 | Exception redirect |
| exc_vector | input | AW | Exception redirect address |
| pc | output | AW | Address of the current instruction |
| in_slot | output | 1 | Current instruction executes as a delay slot |
| nullify | output | 1 | Current instruction is squashed |
| unpredictable | output | 1 | Branch retiring inside a delay slot |

## Verification
Two cases are hard to reach from the ports. The first is a branch inside the slot of a taken branch. The second is an exception that lands while a target is still waiting. The stimulus builds both from a chain of retires. One taken branch is placed just before another branch, so that its slot holds a branch. In another run, the exception is raised on an idle cycle between a taken branch and its slot. The instruction that follows must then continue from the vector and not from the dropped target.

// File: rtl/npc_pkg.sv
package npc_pkg;
    typedef struct packed {
        logic pend;   // a taken target waits for the slot to retire
        logic slot;   // next instruction is a delay slot
        logic kill;   // next instruction is squashed
    } slot_state_t;
endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
    parameter int AW        = 32,
    parameter int FULL_STEP = 4,
    parameter int HALF_STEP = 2
) (
    input  logic [AW-1:0] cur_pc,
    input  logic          half,
    output logic [AW-1:0] seq_pc
);
    localparam logic [AW-1:0] FULL_INC = AW'(FULL_STEP);
    localparam logic [AW-1:0] HALF_INC = AW'(HALF_STEP);

    always_comb begin
        seq_pc = cur_pc + (half ? HALF_INC : FULL_INC);
    end
endmodule

// File: rtl/npc_slot_track.sv
module npc_slot_track
    import npc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          retire,
    input  logic          exc_valid,
    input  logic          is_branch,
    input  logic          taken,
    input  logic          likely,
    input  logic [AW-1:0] target,
    output logic          pend,
    output logic [AW-1:0] pend_tgt,
    output logic          in_slot,
    output logic          nullify,
    output logic          unpredictable
);
    slot_state_t   st_d, st_q;
    logic [AW-1:0] tgt_d, tgt_q;
    logic          accept;

    always_comb begin
        st_d   = st_q;
        tgt_d  = tgt_q;
        accept = retire && is_branch && !st_q.slot;
        if (exc_valid) begin
            st_d = '0;
        end else if (retire) begin
            st_d.pend = accept && taken;
            st_d.slot = accept;
            st_d.kill = accept && likely && !taken;
            if (accept && taken) tgt_d = target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '0;
            tgt_q <= '0;
        end else begin
            st_q  <= st_d;
            tgt_q <= tgt_d;
        end
    end

    assign pend          = st_q.pend;
    assign pend_tgt      = tgt_q;
    assign in_slot       = st_q.slot;
    assign nullify       = st_q.kill;
    assign unpredictable = retire && !exc_valid && st_q.slot && is_branch;

    // R7: a squashed instruction is always a slot
    a_r7_kill_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.kill |-> st_q.slot);
    // R4: a waiting target is consumed by the slot's retire
    a_r4_pend_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !exc_valid && st_q.pend) |=> !st_q.pend);
    // R10: exception clears all slot state
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (st_q == '0));
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
    parameter int              AW       = 32,
    parameter logic [AW-1:0]   RESET_PC = 32'h0000_1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          retire,
    input  logic          half_size,
    input  logic          is_branch,
    input  logic          taken,
    input  logic          likely,
    input  logic [AW-1:0] target,
    input  logic          exc_valid,
    input  logic [AW-1:0] exc_vector,
    output logic [AW-1:0] pc,
    output logic          in_slot,
    output logic          nullify,
    output logic          unpredictable
);
    logic [AW-1:0] pc_d, pc_q;
    logic [AW-1:0] seq_pc, pend_tgt;
    logic          pend;

    npc_incr #(.AW(AW)) u_incr (
        .cur_pc (pc_q),
        .half   (half_size),
        .seq_pc (seq_pc)
    );

    npc_slot_track #(.AW(AW)) u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .retire        (retire),
        .exc_valid     (exc_valid),
        .is_branch     (is_branch),
        .taken         (taken),
        .likely        (likely),
        .target        (target),
        .pend          (pend),
        .pend_tgt      (pend_tgt),
        .in_slot       (in_slot),
        .nullify       (nullify),
        .unpredictable (unpredictable)
    );

    always_comb begin
        pc_d = pc_q;
        if (exc_valid)   pc_d = exc_vector;
        else if (retire) pc_d = pend ? pend_tgt : seq_pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= pc_d;
    end

    assign pc = pc_q;

    // R3: idle cycles hold the PC and flags
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire && !exc_valid) |=> ($stable(pc) && $stable(in_slot) && $stable(nullify)));
    // R10: exception vector is taken
    a_r10_vector: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (pc == $past(exc_vector)));
    // R2: sequential advance outside a slot
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !exc_valid && !in_slot) |=>
        (pc == $past(pc) + (($past(half_size)) ? AW'(2) : AW'(4))));
    // R9: the flag only appears inside a slot
    a_r9_only_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        unpredictable |-> in_slot);
endmodule

// File: tb/sim_npc_unit.sv
module sim_npc_unit;
    localparam int AW = 32;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          retire = 1'b0, half_size = 1'b0, is_branch = 1'b0;
    logic          taken = 1'b0, likely = 1'b0, exc_valid = 1'b0;
    logic [AW-1:0] target = '0, exc_vector = '0;
    logic [AW-1:0] pc;
    logic          in_slot, nullify, unpredictable;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    npc_unit #(.AW(AW), .RESET_PC(32'h0000_1000)) u0 (
        .clk(clk), .rst_n(rst_n), .retire(retire), .half_size(half_size),
        .is_branch(is_branch), .taken(taken), .likely(likely), .target(target),
        .exc_valid(exc_valid), .exc_vector(exc_vector), .pc(pc),
        .in_slot(in_slot), .nullify(nullify), .unpredictable(unpredictable)
    );

    task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle at the falling edge, sample after the rising edge
    task automatic cyc(logic ret, logic hs, logic br, logic tk, logic lk,
                       logic [AW-1:0] tg, logic ex, logic [AW-1:0] vec,
                       logic exp_unp, logic [AW-1:0] exp_pc,
                       logic exp_slot, logic exp_null, string req);
        @(negedge clk);
        retire = ret; half_size = hs; is_branch = br; taken = tk; likely = lk;
        target = tg; exc_valid = ex; exc_vector = vec;
        #1;
        chk({req, " unpredictable"}, AW'(unpredictable), AW'(exp_unp));
        @(posedge clk); #1;
        chk({req, " pc"}, pc, exp_pc);
        chk({req, " in_slot"}, AW'(in_slot), AW'(exp_slot));
        chk({req, " nullify"}, AW'(nullify), AW'(exp_null));
        retire = 0; is_branch = 0; taken = 0; likely = 0; exc_valid = 0;
    endtask

    task automatic t_reset;
        #1;
        chk("R1 pc", pc, 32'h1000);
        chk("R1 in_slot", AW'(in_slot), '0);
        chk("R1 nullify", AW'(nullify), '0);
    endtask

    task automatic t_sequential;
        cyc(1,0,0,0,0,'0,0,'0, 0, 32'h1004, 0, 0, "R2 full");
        cyc(1,1,0,0,0,'0,0,'0, 0, 32'h1006, 0, 0, "R2 half");
        cyc(0,0,0,0,0,'0,0,'0, 0, 32'h1006, 0, 0, "R3 idle");
        cyc(0,1,1,1,0,32'h9000,0,'0, 0, 32'h1006, 0, 0, "R3 idle branch ignored");
    endtask

    task automatic t_taken;
        cyc(1,0,1,1,0,32'h2000,0,'0, 0, 32'h100A, 1, 0, "R4 branch");
        cyc(1,1,0,0,0,'0,0,'0, 0, 32'h2000, 0, 0, "R4 slot to target");
        cyc(1,0,0,0,0,'0,0,'0, 0, 32'h2004, 0, 0, "R5 after target");
    endtask

    task automatic t_not_taken;
        cyc(1,0,1,0,0,'0,0,'0, 0, 32'h2008, 1, 0, "R11 plain not taken");
        cyc(1,0,0,0,0,'0,0,'0, 0, 32'h200C, 0, 0, "R5 slot ends");
    endtask

    task automatic t_likely;
        cyc(1,0,1,0,1,'0,0,'0, 0, 32'h2010, 1, 1, "R7 likely not taken");
        cyc(1,0,0,0,0,'0,0,'0, 0, 32'h2014, 0, 0, "R7 one squash only");
        cyc(1,0,1,1,1,32'h3000,0,'0, 0, 32'h2018, 1, 0, "R8 likely taken");
        cyc(1,0,0,0,0,'0,0,'0, 0, 32'h3000, 0, 0, "R8 redirect");
    endtask

    task automatic t_adjacent_and_nested;
        cyc(1,0,1,1,0,32'h3008,0,'0, 0, 32'h3004, 1, 0, "R6 branch");
        cyc(1,0,0,0,0,'0,0,'0, 0, 32'h3008, 0, 0, "R6 target not slot");
        cyc(1,0,1,1,0,32'h4000,0,'0, 0, 32'h300C, 1, 0, "R9 outer branch");
        cyc(1,0,1,1,0,32'h5000,0,'0, 1, 32'h4000, 0, 0, "R9 branch in slot");
        cyc(1,0,0,0,0,'0,0,'0, 0, 32'h4004, 0, 0, "R9 no late redirect");
    endtask

    task automatic t_exception;
        cyc(1,0,1,1,0,32'h6000,0,'0, 0, 32'h4008, 1, 0, "R10 branch");
        cyc(0,0,0,0,0,'0,1,32'h180, 0, 32'h0180, 0, 0, "R10 exc mid slot");
        cyc(1,0,0,0,0,'0,0,'0, 0, 32'h0184, 0, 0, "R10 target dropped");
        cyc(1,0,1,0,1,'0,0,'0, 0, 32'h0188, 1, 1, "R10 likely setup");
        cyc(1,0,0,0,0,'0,1,32'h200, 0, 32'h0200, 0, 0, "R10 exc clears squash");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #12 rst_n = 1'b1;
        t_reset();
        t_sequential();
        t_taken();
        t_not_taken();
        t_likely();
        t_adjacent_and_nested();
        t_exception();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule